// File: doc/BRIEF.md
# I2C Master Register Block

This block is the software-visible front end of an I2C master. A host reaches it through a byte-wide access port. Each access carries one request, a write flag, a 5-bit byte offset and a data byte. The block decodes an 18-byte window of registers:

- data, address and control registers;
- status registers whose bits are cleared by writing ones;
- a clock divider, an interrupt mask, a transfer-count register and a direct-line control register.

On the engine side, the block drives a transaction-level request port toward an I2C bus engine. The engine does the bit-level signalling, so the block itself never toggles SCL or SDA. Requests are one-cycle pulses: start (with a 7-bit target address and a direction), send a byte, receive a byte, and end the transfer. The engine answers each start, send and receive with a one-cycle response that carries an acknowledge or refusal flag and, for a receive, the byte.

Some register accesses trigger bus work:
- Writing the data register while no transfer is open starts a write transfer, then sends the byte.
- Writing the control register with the go and read bits set opens a read.
- Each data-register read while the busy flag is set fetches one byte. While the pending-byte count in the control register is nonzero, that read also restarts the read, and the count steps down.

While such an access waits for the engine, the host is held off by the ready signal.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset every register reads 0x00, except extended status (offset 0x09), which reads 0x8F, and direct control (offset 0x10), which reads 0x0F.
- R2: Writes are stored and read back at the following offsets:
  - Stored as written: slave data 0x02, high address 0x05, slave address bytes 0x0A/0x0B, clock divider 0x0C, interrupt mask 0x0D, interrupt 0x11.
  - Stored with a mask: mode control 0x07 keeps value & 0xDF, transfer count 0x0E keeps value & 0x77, direct control 0x10 keeps value & 0x07.
- R3: A read of any offset outside the defined set (0x01, 0x03, 0x12 and above) returns 0x00. A write there changes no register.
- R4: A write to status (0x08) clears exactly the bits set in value & 0x0A. A write to extended status (0x09) clears exactly the bits set in value & 0x8F.
- R5: Writing extended control (0x0F) with bit 0 set returns every register to its R1 value, and the written value is not kept. Any write with bit 0 clear is stored.
- R6: When no transfer is open, a data write (0x00) first issues a start toward target address = (low address register 0x04) >> 1 with read = 0, then sends the byte. A successful start sets status bit 0 (transfer), clears status bit 2 (error) and zeroes extended status. When a transfer is already open, only the send is issued.
- R7: A refused address or refused byte clears status bit 0, sets status bit 2 and sets extended-status bit 0 (failed). A refused byte also issues an end. A refused address issues no send.
- R8: A write to the low address register (0x04) issues an end only while a transfer is open.
- R9: Writing control (0x06) with bit 0 (go) and bit 1 (read) both set does the following:
  - If a transfer is open, it clears status bit 0 and issues an end.
  - It then starts a read toward the target.
  - On success it sets status bit 5 (busy), clears status bit 2 and zeroes extended status.
  - On refusal it sets status bit 2 and extended-status bit 0.
  - Go set with read clear only clears status bit 0.
- R10: A data read while status bit 5 is clear returns 0xFF in the request cycle and issues no engine request.
- R11: A data read while status bit 5 is set does the following:
  - It issues a receive and returns the received byte, or 0xFF if the receive is refused.
  - With control bits 5:4 (pending) equal to zero, it clears status bit 5.
  - Otherwise it issues an end and a new read start.
  - In either case control bits 5:4 become pending − 1 modulo 4.
- R12: Accesses that need no engine complete in the request cycle. Engine requests are one-cycle pulses, and at most one of start, send or receive is issued per cycle. An engine-bound access completes only in the cycle its final response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Byte offset in the register window |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Access completes this cycle |
| host_rdata | output | 8 | Read data, valid with host_ready |
| eng_start | output | 1 | Start pulse toward the bus engine |
| eng_read | output | 1 | Direction of the start, 1 = read |
| eng_taddr | output | 7 | Target address for the start |
| eng_send | output | 1 | Send-byte pulse |
| eng_txbyte | output | 8 | Byte to send |
| eng_recv | output | 1 | Receive-byte pulse |
| eng_end | output | 1 | End-transfer pulse |
| eng_rsp | input | 1 | Response strobe for start, send or receive |
| eng_nack | input | 1 | Response is a refusal |
| eng_rxbyte | input | 8 | Received byte, valid with eng_rsp |

## Verification
Plain register accesses raise ready and present read data combinationally in the cycle they are requested. Their effect is visible from the next access onward, so the bench polls ready one nanosecond before each rising edge and checks the latency of plain accesses against zero. An engine request appears one edge after the access is accepted, and the access completes in the cycle the final response is seen. The modelled engine answers three edges after each pulse. For that reason, the bench lets three further edges pass before it compares its engine pulse counters, and it compares register contents only through later reads.

// File: rtl/i2ch_pkg.sv
package i2ch_pkg;

    localparam int AW     = 5;
    localparam int RW     = 8;
    localparam int NREG   = 16;
    localparam int TAW    = 7;
    localparam int PENDW  = 2;
    localparam int IXW    = $clog2(NREG);

    // control bits
    localparam int CT_GO  = 0;
    localparam int CT_RD  = 1;
    localparam int CT_PLO = 4;
    // status bits
    localparam int ST_XFER = 0;
    localparam int ST_ERR  = 2;
    localparam int ST_BUSY = 5;
    // extended status / extended control bits
    localparam int XS_FAIL = 0;
    localparam int XC_SRST = 0;

    localparam logic [RW-1:0] STS_W1C   = 8'h0A;
    localparam logic [RW-1:0] XST_W1C   = 8'h8F;
    localparam logic [RW-1:0] MODE_MASK = 8'hDF;
    localparam logic [RW-1:0] XCNT_MASK = 8'h77;
    localparam logic [RW-1:0] DCTL_MASK = 8'h07;
    localparam logic [RW-1:0] XST_RST   = 8'h8F;
    localparam logic [RW-1:0] DCTL_RST  = 8'h0F;
    localparam logic [RW-1:0] IDLE_BYTE = 8'hFF;

    typedef enum logic [IXW-1:0] {
        RX_MDAT, RX_SDAT, RX_MADR_LO, RX_MADR_HI, RX_CTRL, RX_MODE,
        RX_STAT, RX_XSTAT, RX_SADR_LO, RX_SADR_HI, RX_CDIV, RX_IMASK,
        RX_XCNT, RX_XCTL, RX_DCTL, RX_INTR
    } rix_t;

    // byte offset of each register; the first two sit on even offsets
    function automatic logic [AW-1:0] rix_offset(input int i);
        return (i < 2) ? AW'(2 * i) : AW'(i + 2);
    endfunction

    typedef struct packed {
        logic [RW-1:0] mdat;
        logic [RW-1:0] sdat;
        logic [RW-1:0] madr_lo;
        logic [RW-1:0] madr_hi;
        logic [RW-1:0] ctrl;
        logic [RW-1:0] mode;
        logic [RW-1:0] stat;
        logic [RW-1:0] xstat;
        logic [RW-1:0] sadr_lo;
        logic [RW-1:0] sadr_hi;
        logic [RW-1:0] cdiv;
        logic [RW-1:0] imask;
        logic [RW-1:0] xcnt;
        logic [RW-1:0] xctl;
        logic [RW-1:0] dctl;
        logic [RW-1:0] intr;
    } regs_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_WSTART, SQ_WSEND, SQ_CSTART, SQ_RECV, SQ_RRESTART
    } seq_t;

    typedef struct packed {
        regs_t         r;
        seq_t          sq;
        logic          bus;
        logic [RW-1:0] rxb;
        logic          p_start;
        logic          p_rd;
        logic          p_send;
        logic          p_recv;
        logic          p_end;
    } core_t;

    function automatic regs_t regs_reset();
        regs_t v;
        v       = '0;
        v.xstat = XST_RST;
        v.dctl  = DCTL_RST;
        return v;
    endfunction

    function automatic core_t core_reset();
        core_t c;
        c    = '0;
        c.r  = regs_reset();
        c.sq = SQ_IDLE;
        return c;
    endfunction

endpackage

// File: rtl/i2ch_decode.sv
module i2ch_decode
    import i2ch_pkg::*;
(
    input  logic [AW-1:0] addr,
    output logic          hit,
    output rix_t          idx
);
    logic [NREG-1:0] match;

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_match
            assign match[g] = (addr == rix_offset(g));
        end
    endgenerate

    always_comb begin
        hit = |match;
        idx = RX_MDAT;
        for (int i = 0; i < NREG; i++) begin
            if (match[i]) idx = rix_t'(i[IXW-1:0]);
        end
    end
endmodule

// File: rtl/i2ch_rdmux.sv
module i2ch_rdmux
    import i2ch_pkg::*;
(
    input  regs_t         r,
    input  logic          hit,
    input  rix_t          idx,
    output logic [RW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (hit) begin
            case (idx)
                RX_MDAT:    rdata = IDLE_BYTE;
                RX_SDAT:    rdata = r.sdat;
                RX_MADR_LO: rdata = r.madr_lo;
                RX_MADR_HI: rdata = r.madr_hi;
                RX_CTRL:    rdata = r.ctrl;
                RX_MODE:    rdata = r.mode;
                RX_STAT:    rdata = r.stat;
                RX_XSTAT:   rdata = r.xstat;
                RX_SADR_LO: rdata = r.sadr_lo;
                RX_SADR_HI: rdata = r.sadr_hi;
                RX_CDIV:    rdata = r.cdiv;
                RX_IMASK:   rdata = r.imask;
                RX_XCNT:    rdata = r.xcnt;
                RX_XCTL:    rdata = r.xctl;
                RX_DCTL:    rdata = r.dctl;
                RX_INTR:    rdata = r.intr;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
    import i2ch_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_req,
    input  logic           host_we,
    input  logic [AW-1:0]  host_addr,
    input  logic [RW-1:0]  host_wdata,
    output logic           host_ready,
    output logic [RW-1:0]  host_rdata,
    output logic           eng_start,
    output logic           eng_read,
    output logic [TAW-1:0] eng_taddr,
    output logic           eng_send,
    output logic [RW-1:0]  eng_txbyte,
    output logic           eng_recv,
    output logic           eng_end,
    input  logic           eng_rsp,
    input  logic           eng_nack,
    input  logic [RW-1:0]  eng_rxbyte
);
    core_t d, q;
    logic          hit;
    rix_t          idx;
    logic [RW-1:0] mux_rdata;
    logic [RW-1:0] got_byte;
    logic [PENDW-1:0] pend;

    i2ch_decode u_dec (
        .addr (host_addr),
        .hit  (hit),
        .idx  (idx)
    );

    i2ch_rdmux u_mux (
        .r     (q.r),
        .hit   (hit),
        .idx   (idx),
        .rdata (mux_rdata)
    );

    assign got_byte = eng_nack ? IDLE_BYTE : eng_rxbyte;
    assign pend     = q.r.ctrl[CT_PLO +: PENDW];

    always_comb begin
        d          = q;
        d.p_start  = 1'b0;
        d.p_rd     = 1'b0;
        d.p_send   = 1'b0;
        d.p_recv   = 1'b0;
        d.p_end    = 1'b0;
        host_ready = 1'b0;
        host_rdata = '0;

        case (q.sq)
            SQ_IDLE: begin
                if (host_req && host_we) begin
                    host_ready = 1'b1;
                    if (hit) begin
                        case (idx)
                            RX_MDAT: begin
                                d.r.mdat   = host_wdata;
                                host_ready = 1'b0;
                                if (!q.bus) begin
                                    d.p_start = 1'b1;
                                    d.sq      = SQ_WSTART;
                                end else begin
                                    d.p_send  = 1'b1;
                                    d.sq      = SQ_WSEND;
                                end
                            end
                            RX_MADR_LO: begin
                                d.r.madr_lo = host_wdata;
                                if (q.bus) begin
                                    d.p_end = 1'b1;
                                    d.bus   = 1'b0;
                                end
                            end
                            RX_CTRL: begin
                                d.r.ctrl = host_wdata;
                                if (host_wdata[CT_GO]) begin
                                    if (host_wdata[CT_RD]) begin
                                        if (q.bus) begin
                                            d.r.stat[ST_XFER] = 1'b0;
                                            d.p_end           = 1'b1;
                                            d.bus             = 1'b0;
                                        end
                                        d.p_start  = 1'b1;
                                        d.p_rd     = 1'b1;
                                        d.sq       = SQ_CSTART;
                                        host_ready = 1'b0;
                                    end else begin
                                        d.r.stat[ST_XFER] = 1'b0;
                                    end
                                end
                            end
                            RX_SDAT:    d.r.sdat    = host_wdata;
                            RX_MADR_HI: d.r.madr_hi = host_wdata;
                            RX_MODE:    d.r.mode    = host_wdata & MODE_MASK;
                            RX_STAT:    d.r.stat    = q.r.stat & ~(host_wdata & STS_W1C);
                            RX_XSTAT:   d.r.xstat   = q.r.xstat & ~(host_wdata & XST_W1C);
                            RX_SADR_LO: d.r.sadr_lo = host_wdata;
                            RX_SADR_HI: d.r.sadr_hi = host_wdata;
                            RX_CDIV:    d.r.cdiv    = host_wdata;
                            RX_IMASK:   d.r.imask   = host_wdata;
                            RX_XCNT:    d.r.xcnt    = host_wdata & XCNT_MASK;
                            RX_XCTL: begin
                                if (host_wdata[XC_SRST]) d.r = regs_reset();
                                else                     d.r.xctl = host_wdata;
                            end
                            RX_DCTL:    d.r.dctl    = host_wdata & DCTL_MASK;
                            RX_INTR:    d.r.intr    = host_wdata;
                            default: ;
                        endcase
                    end
                end else if (host_req) begin
                    if (hit && idx == RX_MDAT && q.r.stat[ST_BUSY]) begin
                        d.p_recv = 1'b1;
                        d.sq     = SQ_RECV;
                    end else begin
                        host_ready = 1'b1;
                        host_rdata = mux_rdata;
                    end
                end
            end

            SQ_WSTART: begin
                if (eng_rsp) begin
                    if (eng_nack) begin
                        d.r.stat[ST_XFER]  = 1'b0;
                        d.r.stat[ST_ERR]   = 1'b1;
                        d.r.xstat[XS_FAIL] = 1'b1;
                        d.sq               = SQ_IDLE;
                        host_ready         = 1'b1;
                    end else begin
                        d.r.stat[ST_XFER]  = 1'b1;
                        d.r.stat[ST_ERR]   = 1'b0;
                        d.r.xstat          = '0;
                        d.bus              = 1'b1;
                        d.p_send           = 1'b1;
                        d.sq               = SQ_WSEND;
                    end
                end
            end

            SQ_WSEND: begin
                if (eng_rsp) begin
                    host_ready = 1'b1;
                    d.sq       = SQ_IDLE;
                    if (eng_nack) begin
                        d.r.stat[ST_XFER]  = 1'b0;
                        d.r.stat[ST_ERR]   = 1'b1;
                        d.r.xstat[XS_FAIL] = 1'b1;
                        d.p_end            = 1'b1;
                        d.bus              = 1'b0;
                    end
                end
            end

            SQ_CSTART, SQ_RRESTART: begin
                if (eng_rsp) begin
                    host_ready = 1'b1;
                    host_rdata = (q.sq == SQ_RRESTART) ? q.rxb : '0;
                    d.sq       = SQ_IDLE;
                    if (eng_nack) begin
                        d.r.stat[ST_XFER]  = 1'b0;
                        d.r.stat[ST_ERR]   = 1'b1;
                        d.r.xstat[XS_FAIL] = 1'b1;
                    end else begin
                        d.r.stat[ST_BUSY]  = 1'b1;
                        d.r.stat[ST_ERR]   = 1'b0;
                        d.r.xstat          = '0;
                        d.bus              = 1'b1;
                    end
                end
            end

            SQ_RECV: begin
                if (eng_rsp) begin
                    d.r.ctrl[CT_PLO +: PENDW] = pend - PENDW'(1);
                    if (pend == '0) begin
                        d.r.stat[ST_BUSY] = 1'b0;
                        host_ready        = 1'b1;
                        host_rdata        = got_byte;
                        d.sq              = SQ_IDLE;
                    end else begin
                        d.rxb     = got_byte;
                        d.p_end   = 1'b1;
                        d.bus     = 1'b0;
                        d.p_start = 1'b1;
                        d.p_rd    = 1'b1;
                        d.sq      = SQ_RRESTART;
                    end
                end
            end

            default: d.sq = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= core_reset();
        else        q <= d;
    end

    assign eng_start  = q.p_start;
    assign eng_read   = q.p_rd;
    assign eng_send   = q.p_send;
    assign eng_recv   = q.p_recv;
    assign eng_end    = q.p_end;
    assign eng_taddr  = q.r.madr_lo[RW-1:1];
    assign eng_txbyte = q.r.mdat;

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_start, eng_send, eng_recv})) else $error("one request"); // R12

    AST_RECV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_recv |=> !eng_recv) else $error("recv pulse"); // R12

    AST_SEND_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        eng_send |-> q.bus) else $error("send without open transfer"); // R6

    AST_IDLE_RD_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sq == SQ_IDLE && host_req && !host_we && host_addr == rix_offset(RX_MDAT)
         && !q.r.stat[ST_BUSY]) |-> (host_ready && host_rdata == IDLE_BYTE))
        else $error("idle data read"); // R10

    AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sq == SQ_IDLE && host_req && host_we && host_addr == rix_offset(RX_STAT))
        |=> ((q.r.stat & $past(host_wdata & STS_W1C)) == '0)) else $error("status clear"); // R4

    AST_MADR_END: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sq == SQ_IDLE && host_req && host_we && host_addr == rix_offset(RX_MADR_LO) && q.bus)
        |=> eng_end) else $error("address write end"); // R8

    AST_NACK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sq == SQ_WSTART && eng_rsp && eng_nack)
        |=> (q.r.stat[ST_ERR] && q.r.xstat[XS_FAIL] && !q.r.stat[ST_XFER])) else $error("refusal flags"); // R7

    AST_SRST: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sq == SQ_IDLE && host_req && host_we && host_addr == rix_offset(RX_XCTL) && host_wdata[XC_SRST])
        |=> (q.r.xstat == XST_RST && q.r.dctl == DCTL_RST && q.r.xctl == '0)) else $error("soft reset"); // R5
endmodule

// File: tb/tb_i2c_host_regs.sv
`timescale 1ns/1ps
module tb_i2c_host_regs;
    logic clk = 1'b0, rst_n = 1'b0;
    logic host_req = 1'b0, host_we = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic host_ready;
    logic [7:0] host_rdata;
    logic eng_start, eng_read, eng_send, eng_recv, eng_end;
    logic [6:0] eng_taddr;
    logic [7:0] eng_txbyte;
    logic eng_rsp, eng_nack;
    logic [7:0] eng_rxbyte;

    always #2 clk = ~clk;

    i2c_host_regs dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .eng_start(eng_start), .eng_read(eng_read),
        .eng_taddr(eng_taddr), .eng_send(eng_send), .eng_txbyte(eng_txbyte),
        .eng_recv(eng_recv), .eng_end(eng_end), .eng_rsp(eng_rsp),
        .eng_nack(eng_nack), .eng_rxbyte(eng_rxbyte)
    );

    // bus engine model: target 0x50 answers, byte 0xEE is refused
    int n_start, n_send, n_recv, n_end;
    logic [6:0] last_taddr;
    logic last_rd;
    logic [7:0] last_tx, rx_next, pbyte;
    logic [1:0] tmr;
    logic pnack;
    logic rx_fail = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_start <= 0; n_send <= 0; n_recv <= 0; n_end <= 0;
            last_taddr <= '0; last_rd <= 1'b0; last_tx <= '0;
            rx_next <= 8'hA0; pbyte <= '0; tmr <= '0; pnack <= 1'b0;
            eng_rsp <= 1'b0; eng_nack <= 1'b0; eng_rxbyte <= '0;
        end else begin
            eng_rsp <= 1'b0;
            if (eng_end) n_end <= n_end + 1;
            if (eng_start) begin
                n_start <= n_start + 1; last_taddr <= eng_taddr; last_rd <= eng_read;
                tmr <= 2'd2; pnack <= (eng_taddr != 7'h50);
            end else if (eng_send) begin
                n_send <= n_send + 1; last_tx <= eng_txbyte;
                tmr <= 2'd2; pnack <= (eng_txbyte == 8'hEE);
            end else if (eng_recv) begin
                n_recv <= n_recv + 1; tmr <= 2'd2; pnack <= rx_fail;
                pbyte <= rx_next; rx_next <= rx_next + 8'd1;
            end else if (tmr != 2'd0) begin
                tmr <= tmr - 2'd1;
                if (tmr == 2'd1) begin
                    eng_rsp <= 1'b1; eng_nack <= pnack; eng_rxbyte <= pbyte;
                end
            end
        end
    end

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [4:0] a, input logic [7:0] wd,
                       output logic [7:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd; lat = 0;
        #1;
        while (host_ready !== 1'b1) begin
            @(negedge clk); #1; lat++;
        end
        rd = host_rdata;
        @(posedge clk); #1;
        host_req = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] wd);
        logic [7:0] dummy; int lat;
        acc(1'b1, a, wd, dummy, lat);
    endtask

    task automatic rdchk(input string tag, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] v; int lat;
        acc(1'b0, a, 8'h00, v, lat);
        chk(tag, v, exp);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #1;
    endtask

    // {offset, written value, expected readback}
    localparam logic [23:0] VEC [15] = '{
        {8'h07, 8'hFF, 8'hDF}, {8'h0E, 8'hFF, 8'h77}, {8'h10, 8'hFF, 8'h07},
        {8'h0C, 8'h5A, 8'h5A}, {8'h0D, 8'hC3, 8'hC3}, {8'h05, 8'h3C, 8'h3C},
        {8'h0A, 8'h81, 8'h81}, {8'h0B, 8'h7E, 8'h7E}, {8'h02, 8'h99, 8'h99},
        {8'h11, 8'h44, 8'h44}, {8'h0F, 8'hFE, 8'hFE}, {8'h01, 8'h55, 8'h00},
        {8'h03, 8'hAA, 8'h00}, {8'h12, 8'hFF, 8'h00}, {8'h1F, 8'h11, 8'h00}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int lat;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 xstat", 5'h09, 8'h8F);
        rdchk("R1 dctl", 5'h10, 8'h0F);
        rdchk("R1 ctrl", 5'h06, 8'h00);
        rdchk("R1 stat", 5'h08, 8'h00);
        rdchk("R1 cdiv", 5'h0C, 8'h00);

        // R2 / R3 / R5 vector table
        for (int i = 0; i < 15; i++) begin
            acc(1'b1, VEC[i][20:16], VEC[i][15:8], v, lat);
            chk("R12 plain write latency", lat, 0);
            acc(1'b0, VEC[i][20:16], 8'h00, v, lat);
            chk((VEC[i][23:16] inside {8'h01, 8'h03, 8'h12, 8'h1F}) ? "R3 undefined read" : "R2 readback",
                v, VEC[i][7:0]);
        end
        rdchk("R3 sdat untouched by undefined writes", 5'h02, 8'h99);
        rdchk("R5 xctl stored without bit0", 5'h0F, 8'hFE);

        // R5 soft reset
        wr(5'h0F, 8'h01);
        rdchk("R5 xstat", 5'h09, 8'h8F);
        rdchk("R5 dctl", 5'h10, 8'h0F);
        rdchk("R5 mode", 5'h07, 8'h00);
        rdchk("R5 xctl not kept", 5'h0F, 8'h00);
        rdchk("R5 sdat", 5'h02, 8'h00);

        // R4 extended status clear
        wr(5'h09, 8'h0F);
        rdchk("R4 xstat partial", 5'h09, 8'h80);
        wr(5'h09, 8'hFF);
        rdchk("R4 xstat all", 5'h09, 8'h00);

        // R6 write transfer
        wr(5'h04, 8'hA0);
        settle();
        chk("R8 no end when idle", n_end, 0);
        acc(1'b1, 5'h00, 8'h11, v, lat);
        chk("R12 engine write stalls", int'(lat > 0), 1);
        settle();
        chk("R6 start count", n_start, 1);
        chk("R6 start dir", last_rd, 0);
        chk("R6 target", last_taddr, 7'h50);
        chk("R6 send count", n_send, 1);
        chk("R6 sent byte", last_tx, 8'h11);
        rdchk("R6 status", 5'h08, 8'h01);
        rdchk("R6 xstat", 5'h09, 8'h00);
        acc(1'b0, 5'h00, 8'h00, v, lat);
        chk("R10 idle data read", v, 8'hFF);
        chk("R10 idle data latency", lat, 0);
        wr(5'h00, 8'h22);
        settle();
        chk("R6 no restart", n_start, 1);
        chk("R6 second send", n_send, 2);
        settle();
        chk("R10 no recv", n_recv, 0);

        // R7 refused byte
        wr(5'h00, 8'hEE);
        settle();
        rdchk("R7 status after refused byte", 5'h08, 8'h04);
        rdchk("R7 xstat", 5'h09, 8'h01);
        chk("R7 end issued", n_end, 1);
        wr(5'h08, 8'hFF);
        rdchk("R4 status keeps unmasked bits", 5'h08, 8'h04);

        // R7 refused address
        wr(5'h04, 8'h10);
        settle();
        chk("R8 no end when idle", n_end, 1);
        wr(5'h00, 8'h33);
        settle();
        chk("R7 start attempted", n_start, 2);
        chk("R7 no send", n_send, 3);
        rdchk("R7 status", 5'h08, 8'h04);
        rdchk("R7 xstat", 5'h09, 8'h01);

        // R8 end on address write while open
        wr(5'h04, 8'hA0);
        wr(5'h00, 8'h44);
        settle();
        rdchk("R6 status reopened", 5'h08, 8'h01);
        rdchk("R6 xstat zeroed", 5'h09, 8'h00);
        wr(5'h04, 8'hA0);
        settle();
        chk("R8 end when open", n_end, 2);

        // R9 go without read
        wr(5'h06, 8'h01);
        rdchk("R9 go-write clears xfer", 5'h08, 8'h00);

        // R9 / R11 read with two pending bytes
        wr(5'h06, 8'h23);
        settle();
        chk("R9 no end when closed", n_end, 2);
        chk("R9 read start", n_start, 4);
        chk("R9 read dir", last_rd, 1);
        rdchk("R9 busy set", 5'h08, 8'h20);
        rdchk("R11 byte 0", 5'h00, 8'hA0);
        settle();
        chk("R11 restart start", n_start, 5);
        chk("R11 restart end", n_end, 3);
        rdchk("R11 pending 1", 5'h06, 8'h13);
        rdchk("R11 byte 1", 5'h00, 8'hA1);
        rdchk("R11 pending 0", 5'h06, 8'h03);
        rdchk("R11 byte 2", 5'h00, 8'hA2);
        settle();
        chk("R11 no restart at zero", n_start, 6);
        rdchk("R11 busy cleared", 5'h08, 8'h00);
        rdchk("R11 pending wraps", 5'h06, 8'h33);
        rdchk("R10 after drain", 5'h00, 8'hFF);
        chk("R10 recv count", n_recv, 3);

        // R9 read start on open transfer, R11 refused receive
        wr(5'h06, 8'h03);
        settle();
        chk("R9 end before read", n_end, 5);
        chk("R9 start", n_start, 7);
        rdchk("R9 busy", 5'h08, 8'h20);
        rx_fail = 1'b1;
        rdchk("R11 refused receive", 5'h00, 8'hFF);
        rx_fail = 1'b0;
        rdchk("R11 busy cleared", 5'h08, 8'h00);
        rdchk("R11 pending wraps", 5'h06, 8'h33);

        // R9 refused read start
        wr(5'h04, 8'h10);
        settle();
        chk("R8 end", n_end, 6);
        wr(5'h06, 8'h03);
        rdchk("R9 refused status", 5'h08, 8'h04);
        rdchk("R9 refused xstat", 5'h09, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule